// File: doc/BRIEF.md
# Serial Port FIFO Control and Trigger Logic

This block holds the receive and transmit byte queues of one serial channel. A write-only control register sets them up. Each write can turn queueing on or off, clear either queue, pick the ready-pin mode and choose a trigger level. The receive side of the channel pushes bytes that the host pops, and the host pushes bytes that the transmit side pops. The block watches both fill counts and raises an interrupt request for each direction. It also drives two active-low ready pins for a host or DMA engine.

Both directions share one trigger level. Each control write sets it from one of two 2-bit fields. The receive field is always accepted. The transmit field is accepted only while the `featEn` input is high, and when it is accepted it wins over the receive field in the same write. The transmit interrupt remembers whether the queue was filled past the trigger since it last ran empty. If it was not, the interrupt waits for the queue to empty instead of firing when the count drops below the trigger.

Top module: `sio_fifo_ctrl`

## Requirements
- R1: A control write with bit 0 at 0 turns queueing off and empties both queues. While queueing is off, pushes and pops are ignored and both interrupts stay low.
- R2: A control write with bit 0 at 1 turns queueing on. In that same write, bit 1 empties only the receive queue and bit 2 empties only the transmit queue. The other queue keeps its count.
- R3: Each queue holds 16 bytes and pops them in push order. The byte at the head is always visible on the pop-data output. A push into a full queue and a pop from an empty queue are both ignored.
- R4: A trigger field of 2'b00 selects a level of 1, 2'b01 selects 4, 2'b10 selects 8 and 2'b11 selects 14. After reset the level is 1.
- R5: Every control write loads the active level. It uses bits [5:4] when `featEn` is 1 and bits [7:6] otherwise, so the transmit field has no effect while `featEn` is 0.
- R6: `rxIrq` is high exactly while the receive count is at or above the active level.
- R7: `txIrq` goes high when a pop empties the transmit queue. It also goes high when a pop takes the count below the level, but only if a push had taken the count above the level since the queue was last empty. It also rises when the queue is emptied by a control write. An accepted push clears it.
- R8: With bit 3 last written as 0 (normal mode), `rxRdyN` is low while the receive queue is not empty, and `txRdyN` is low while the transmit queue is empty.
- R9: With bit 3 last written as 1 (DMA mode), `rxRdyN` goes low once the receive count reaches the level and stays low until the queue empties. `txRdyN` is low while the transmit queue is not full.
- R10: After reset, both counts are 0, queueing is off, both interrupts are low, `rxRdyN` is high and `txRdyN` is low.
- R11: A push and a pop accepted in the same cycle leave the count unchanged. A control write that empties a queue wins over a push or pop to that queue in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Control register write strobe |
| cfgData | input | 8 | Control register write value |
| featEn | input | 1 | Allows the transmit trigger field to load |
| rxPush | input | 1 | Push strobe, receive queue |
| rxPushData | input | 8 | Byte to push, receive queue |
| rxPop | input | 1 | Pop strobe, receive queue |
| rxPopData | output | 8 | Head byte, receive queue |
| txPush | input | 1 | Push strobe, transmit queue |
| txPushData | input | 8 | Byte to push, transmit queue |
| txPop | input | 1 | Pop strobe, transmit queue |
| txPopData | output | 8 | Head byte, transmit queue |
| rxCount | output | 5 | Receive fill count, 0 to 16 |
| txCount | output | 5 | Transmit fill count, 0 to 16 |
| rxIrq | output | 1 | Receive interrupt request |
| txIrq | output | 1 | Transmit interrupt request |
| rxRdyN | output | 1 | Receive ready, active low |
| txRdyN | output | 1 | Transmit ready, active low |
| fifoOn | output | 1 | Queueing enabled |

## Verification
A pointer or count that drifts shows up on the pop-data output or the count ports in the cycle after the stroke that caused it. The bench therefore checks head bytes before every pop through a full fill and drain. The transmit memory bit and the DMA receive hold bit cannot be seen directly. A wrong value in either one appears only at a later pop, when the interrupt or ready pin takes the wrong value. So the bench drives sequences that cross the trigger level in both directions and then checks the output one clock after each pop.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  localparam int CH_RX = 0;
  localparam int CH_TX = 1;

  // per-queue strobes from control to datapath, bit index = channel
  typedef struct packed {
    logic [1:0] clr;
    logic [1:0] push;
    logic [1:0] pop;
  } fifoStrb_t;

  function automatic int unsigned trigLevel(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/sfc_datapath.sv
module sfc_datapath
  import sfc_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fifoStrb_t              strb,
  input  logic [1:0][DW-1:0]     wrData,
  output logic [1:0][DW-1:0]     rdData,
  output logic [1:0][CW-1:0]     level
);

  for (genvar ch = 0; ch < 2; ch++) begin : gQueue
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] rdPtr;
    logic [PW-1:0] wrPtr;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdPtr <= '0;
        wrPtr <= '0;
        cnt   <= '0;
      end else if (strb.clr[ch]) begin
        rdPtr <= '0;
        wrPtr <= '0;
        cnt   <= '0;
      end else begin
        if (strb.push[ch]) wrPtr <= nextPtr(wrPtr);
        if (strb.pop[ch])  rdPtr <= nextPtr(rdPtr);
        case ({strb.push[ch], strb.pop[ch]})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
    end

    // storage carries no reset; only accepted pushes write it
    always_ff @(posedge clk) begin
      if (strb.push[ch] && !strb.clr[ch]) mem[wrPtr] <= wrData[ch];
    end

    assign rdData[ch] = mem[rdPtr];
    assign level[ch]  = cnt;
  end

endmodule

// File: rtl/sfc_control.sv
module sfc_control
  import sfc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [7:0]         cfgData,
  input  logic               featEn,
  input  logic [1:0]         pushReq,
  input  logic [1:0]         popReq,
  input  logic [1:0][CW-1:0] level,
  output fifoStrb_t          strb,
  output logic               rxIrq,
  output logic               txIrq,
  output logic               rxRdyN,
  output logic               txRdyN,
  output logic               fifoOn
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic          dmaMode;
  logic [1:0]    trigSel;
  logic [CW-1:0] trigLvl;
  logic          wrOn;
  logic          wrOff;
  logic          txFlag;
  logic          txFilled;
  logic          rxHold;
  logic          rxDmaAct;
  logic [CW-1:0] txNext;

  assign wrOn    = cfgWe & cfgData[0];
  assign wrOff   = cfgWe & ~cfgData[0];
  assign trigLvl = CW'(trigLevel(trigSel));

  // strobe generation: clear wins over push/pop, bounds gate acceptance
  always_comb begin
    strb = '0;
    strb.clr[CH_RX] = wrOff | (wrOn & cfgData[1]);
    strb.clr[CH_TX] = wrOff | (wrOn & cfgData[2]);
    for (int ch = 0; ch < 2; ch++) begin
      strb.push[ch] = fifoOn & pushReq[ch] & (level[ch] != FULL) & ~strb.clr[ch];
      strb.pop[ch]  = fifoOn & popReq[ch]  & (level[ch] != '0)   & ~strb.clr[ch];
    end
  end

  // control register fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoOn  <= 1'b0;
      dmaMode <= 1'b0;
      trigSel <= 2'b00;
    end else if (cfgWe) begin
      fifoOn  <= cfgData[0];
      dmaMode <= cfgData[3];
      trigSel <= featEn ? cfgData[5:4] : cfgData[7:6];
    end
  end

  // transmit count after this cycle's accepted strobes
  always_comb begin
    case ({strb.push[CH_TX], strb.pop[CH_TX]})
      2'b10:   txNext = level[CH_TX] + 1'b1;
      2'b01:   txNext = level[CH_TX] - 1'b1;
      default: txNext = level[CH_TX];
    endcase
  end

  // transmit interrupt state: flag plus "filled past trigger" memory
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFlag   <= 1'b1;
      txFilled <= 1'b0;
    end else if (strb.clr[CH_TX]) begin
      txFlag   <= 1'b1;
      txFilled <= 1'b0;
    end else if (strb.push[CH_TX]) begin
      txFlag <= 1'b0;
      if (txNext > trigLvl) txFilled <= 1'b1;
    end else if (strb.pop[CH_TX]) begin
      if (txNext == '0) begin
        txFlag   <= 1'b1;
        txFilled <= 1'b0;
      end else if (txFilled && (txNext < trigLvl)) begin
        txFlag <= 1'b1;
      end
    end
  end

  // DMA receive ready: set at trigger, held until empty
  assign rxDmaAct = (level[CH_RX] >= trigLvl) | (rxHold & (level[CH_RX] != '0));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxHold <= 1'b0;
    else       rxHold <= rxDmaAct;
  end

  assign rxIrq  = level[CH_RX] >= trigLvl;
  assign txIrq  = txFlag & fifoOn;
  assign rxRdyN = dmaMode ? ~rxDmaAct : (level[CH_RX] == '0);
  assign txRdyN = dmaMode ? (level[CH_TX] == FULL) : (level[CH_TX] != '0);

endmodule

// File: rtl/sio_fifo_ctrl.sv
module sio_fifo_ctrl
  import sfc_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgWe,
  input  logic [7:0]                   cfgData,
  input  logic                         featEn,
  input  logic                         rxPush,
  input  logic [DW-1:0]                rxPushData,
  input  logic                         rxPop,
  output logic [DW-1:0]                rxPopData,
  input  logic                         txPush,
  input  logic [DW-1:0]                txPushData,
  input  logic                         txPop,
  output logic [DW-1:0]                txPopData,
  output logic [$clog2(DEPTH+1)-1:0]   rxCount,
  output logic [$clog2(DEPTH+1)-1:0]   txCount,
  output logic                         rxIrq,
  output logic                         txIrq,
  output logic                         rxRdyN,
  output logic                         txRdyN,
  output logic                         fifoOn
);

  localparam int CW = $clog2(DEPTH + 1);

  fifoStrb_t          strb;
  logic [1:0][DW-1:0] wrData;
  logic [1:0][DW-1:0] rdData;
  logic [1:0][CW-1:0] level;

  assign wrData[CH_RX] = rxPushData;
  assign wrData[CH_TX] = txPushData;
  assign rxPopData     = rdData[CH_RX];
  assign txPopData     = rdData[CH_TX];
  assign rxCount       = level[CH_RX];
  assign txCount       = level[CH_TX];

  sfc_control #(.DEPTH(DEPTH)) uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgData (cfgData),
    .featEn  (featEn),
    .pushReq ({txPush, rxPush}),
    .popReq  ({txPop, rxPop}),
    .level   (level),
    .strb    (strb),
    .rxIrq   (rxIrq),
    .txIrq   (txIrq),
    .rxRdyN  (rxRdyN),
    .txRdyN  (txRdyN),
    .fifoOn  (fifoOn)
  );

  sfc_datapath #(.DW(DW), .DEPTH(DEPTH)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .rdData (rdData),
    .level  (level)
  );

endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          cfgWe,
  input logic [7:0]    cfgData,
  input logic          rxPush,
  input logic          rxPop,
  input logic          txPush,
  input logic [CW-1:0] rxCount,
  input logic [CW-1:0] txCount,
  input logic          rxIrq,
  input logic          txIrq,
  input logic          rxRdyN,
  input logic          txRdyN,
  input logic          fifoOn
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic dmaSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      dmaSeen <= 1'b0;
    else if (cfgWe) dmaSeen <= cfgData[3];
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount <= FULL) && (txCount <= FULL));

  a_r3_full_push_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && !rxPop && !cfgWe && rxCount == FULL) |=> (rxCount == FULL));

  a_r1_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && !cfgData[0]) |=> (rxCount == '0 && txCount == '0 && !fifoOn));

  a_r2_tx_clear_keeps_rx: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgData[0] && cfgData[2] && !cfgData[1] && !rxPush && !rxPop)
    |=> (txCount == '0 && $stable(rxCount)));

  a_r7_push_clears_txirq: assert property (@(posedge clk) disable iff (!rstN)
    (fifoOn && txPush && txCount != FULL && !cfgWe) |=> !txIrq);

  a_r6_empty_no_rxirq: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == '0) |-> !rxIrq);

  a_r8_normal_ready: assert property (@(posedge clk) disable iff (!rstN)
    !dmaSeen |-> ((rxRdyN == (rxCount == '0)) && (txRdyN == (txCount != '0))));

  a_r9_dma_tx_ready: assert property (@(posedge clk) disable iff (!rstN)
    dmaSeen |-> (txRdyN == (txCount == FULL)));

endmodule

bind sio_fifo_ctrl sfc_checker #(.DEPTH(DEPTH)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .cfgWe   (cfgWe),
  .cfgData (cfgData),
  .rxPush  (rxPush),
  .rxPop   (rxPop),
  .txPush  (txPush),
  .rxCount (rxCount),
  .txCount (txCount),
  .rxIrq   (rxIrq),
  .txIrq   (txIrq),
  .rxRdyN  (rxRdyN),
  .txRdyN  (txRdyN),
  .fifoOn  (fifoOn)
);

// File: tb/tb_sio_fifo_ctrl.sv
module tb_sio_fifo_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [7:0] cfgData = '0;
  logic       featEn = 1'b0;
  logic       rxPush = 1'b0, rxPop = 1'b0, txPush = 1'b0, txPop = 1'b0;
  logic [7:0] rxPushData = '0, txPushData = '0;
  logic [7:0] rxPopData, txPopData;
  logic [4:0] rxCount, txCount;
  logic       rxIrq, txIrq, rxRdyN, txRdyN, fifoOn;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_fifo_ctrl dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData), .featEn(featEn),
    .rxPush(rxPush), .rxPushData(rxPushData), .rxPop(rxPop), .rxPopData(rxPopData),
    .txPush(txPush), .txPushData(txPushData), .txPop(txPop), .txPopData(txPopData),
    .rxCount(rxCount), .txCount(txCount), .rxIrq(rxIrq), .txIrq(txIrq),
    .rxRdyN(rxRdyN), .txRdyN(txRdyN), .fifoOn(fifoOn)
  );

  typedef struct packed {
    logic       we;
    logic [7:0] d;
    logic       fe;
    logic       rp, ro, tp, to;
    logic [4:0] rxc, txc;
    logic       ri, ti, rrn, trn;
  } vec_t;

  // stimulus, then expected outputs one clock later
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd1, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd2, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd1, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b1, 8'h41, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd2, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd3, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd4, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 5'd4, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd3, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 8'h03, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd1, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd1, 5'd1, 1'b1, 1'b0, 1'b0, 1'b1},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd1, 5'd2, 1'b1, 1'b0, 1'b0, 1'b1},
    '{1'b1, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b1, 8'h31, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 8'h31, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one clock: drive at falling edge, outputs settle after the rising edge
  task automatic cyc(input logic we, input logic [7:0] d, input logic fe,
                     input logic rp, input logic ro, input logic tp, input logic to,
                     input logic [7:0] dat);
    @(negedge clk);
    cfgWe = we; cfgData = d; featEn = fe;
    rxPush = rp; rxPop = ro; txPush = tp; txPop = to;
    rxPushData = dat; txPushData = dat;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10 rxCount", rxCount, 0);
    chk("R10 txCount", txCount, 0);
    chk("R10 fifoOn", fifoOn, 0);
    chk("R10 rxIrq", rxIrq, 0);
    chk("R10 txIrq", txIrq, 0);
    chk("R10 rxRdyN", rxRdyN, 1);
    chk("R10 txRdyN", txRdyN, 0);
    @(negedge clk);
    rstN = 1'b1;

    // table walk: R2 R4 R5 R6 R7 R8 R11
    for (int i = 0; i < NVEC; i++) begin
      cyc(VECS[i].we, VECS[i].d, VECS[i].fe, VECS[i].rp, VECS[i].ro,
          VECS[i].tp, VECS[i].to, 8'(i));
      chk($sformatf("vec%0d R2/R11 rxCount", i), rxCount, VECS[i].rxc);
      chk($sformatf("vec%0d R2/R11 txCount", i), txCount, VECS[i].txc);
      chk($sformatf("vec%0d R5/R6 rxIrq", i), rxIrq, VECS[i].ri);
      chk($sformatf("vec%0d R7 txIrq", i), txIrq, VECS[i].ti);
      chk($sformatf("vec%0d R8 rxRdyN", i), rxRdyN, VECS[i].rrn);
      chk($sformatf("vec%0d R8 txRdyN", i), txRdyN, VECS[i].trn);
    end

    // R3: fill past full, drain in order, pop when empty
    cyc(1'b1, 8'h07, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R2 rx clear", rxCount, 0);
    for (int i = 0; i < 17; i++) cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'(8'h30 + i));
    chk("R3 full count", rxCount, 16);
    for (int i = 0; i < 16; i++) begin
      chk("R3 head order", rxPopData, 8'h30 + i);
      cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    end
    chk("R3 drained", rxCount, 0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    chk("R3 empty pop ignored", rxCount, 0);

    // R11: clear wins over a push in the same cycle
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h11);
    cyc(1'b1, 8'h03, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h12);
    chk("R11 clear beats push", rxCount, 0);

    // R1: disabled queues ignore pushes
    cyc(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R1 fifoOn off", fifoOn, 0);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h55);
    chk("R1 rx push ignored", rxCount, 0);
    chk("R1 tx push ignored", txCount, 0);
    chk("R1 txIrq low", txIrq, 0);
    chk("R1 rxIrq low", rxIrq, 0);

    // R7: level 4, filled past trigger
    cyc(1'b1, 8'h41, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R7 empty irq", txIrq, 1);
    for (int i = 0; i < 6; i++) cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'(i));
    chk("R7 push clears", txIrq, 0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R7 at 5", txIrq, 0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R7 at 4", txIrq, 0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R7 below trigger", txIrq, 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    chk("R7 push clears again", txIrq, 0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R7 below again", txIrq, 1);
    // R7: never filled past trigger, fires only on empty
    cyc(1'b1, 8'h45, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R7 tx clear count", txCount, 0);
    for (int i = 0; i < 3; i++) cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'(i));
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R7 unfilled at 2", txIrq, 0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R7 unfilled at 1", txIrq, 0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R7 unfilled empty", txIrq, 1);

    // R9: DMA mode, level 4
    cyc(1'b1, 8'h49, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    for (int i = 0; i < 3; i++) cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'(i));
    chk("R9 below trigger rxRdyN", rxRdyN, 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h03);
    chk("R9 at trigger rxRdyN", rxRdyN, 0);
    for (int i = 0; i < 3; i++) cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    chk("R9 held at 1 rxRdyN", rxRdyN, 0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    chk("R9 empty rxRdyN", rxRdyN, 1);
    chk("R9 tx empty txRdyN", txRdyN, 0);
    for (int i = 0; i < 15; i++) cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'(i));
    chk("R9 tx 15 txRdyN", txRdyN, 0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0F);
    chk("R9 tx full txRdyN", txRdyN, 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R9 tx 15 again txRdyN", txRdyN, 0);

    // R4: code 2'b10 gives level 8
    cyc(1'b1, 8'h81, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    for (int i = 0; i < 7; i++) cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'(i));
    chk("R4 level8 at 7", rxIrq, 0);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h07);
    chk("R4 level8 at 8", rxIrq, 1);
    idle();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule